// File: doc/BRIEF.md
# Infrared Waveform List Player

The block plays an infrared transmit pattern that software has laid out in memory as a length-prefixed list of 16-bit segment descriptors. A one-cycle start pulse hands it the byte address of the list. The block reads the 32-bit byte-length header as two halfword reads. It then fetches descriptors one at a time over a request/valid read port and plays each one as a run of signal frames on `ir_out`. The next descriptor is fetched while the current one plays, so consecutive segments join without a gap.

Each frame lasts one period of one of two programmable pulse shapes. A shape is a period and high-time pair, A or B. A carrier segment drives the output high for the first part of every frame. A silent segment holds the output low for the same number of frames. When the last descriptor has played, the block returns to idle on its own and raises a sticky done flag. The flag stays set until software clears it with a write-1 pulse.

States: `ST_IDLE` moves to `ST_LEN_LO` on start. `ST_LEN_LO` moves to `ST_LEN_HI` when the low header half is returned. `ST_LEN_HI` moves to `ST_IDLE` (bad length, done) or to `ST_LOAD`. `ST_LOAD` moves to `ST_PLAY` once a descriptor is buffered. `ST_PLAY` loops to itself on a back-to-back segment, falls back to `ST_LOAD` if the next descriptor has not arrived yet, and moves to `ST_IDLE` with done after the final frame.

Top module: `ir_wave_seq`

## Requirements
- R1: The header is a little-endian 32-bit byte length. It is read as a halfword at `base_addr` (low half) and then at `base_addr+2` (high half). Descriptors are read from `base_addr+4` upward, 2 bytes apart, in list order.
- R2: Descriptor bit 15 selects carrier (1) or silent (0) frames. Bit 14 selects shape B (1) or shape A (0). Bits 13:0 give the frame count, and a count of 0 plays as 1 frame.
- R3: A frame lasts P clock cycles, where P is the selected shape's period. In a carrier segment `ir_out` is high during the first H cycles of each frame, where H is the shape's high time. In a silent segment it stays low.
- R4: Segments play strictly in list order. Each segment follows the previous one with no idle cycle, provided every memory read completes within the length of the segment being played.
- R5: After the last frame of the last descriptor, `busy` falls and `done` rises on the same clock edge.
- R6: A header length of 0 or an odd length ends the run with `done` set. No descriptor is played, and `ir_out` never goes high.
- R7: A header length above 512 bytes is clamped to 256 descriptors. Any descriptor beyond the 256th is never played.
- R8: `done` holds its value until `done_clr` is pulsed. A `done_clr` while idle clears it by the next cycle. If a set and a clear fall on the same cycle, the set wins.
- R9: A `start` pulse while `busy` is high is ignored, and the running list plays on unchanged.
- R10: `ir_out` is low whenever `busy` is low, including after reset. After reset, `busy`, `done` and `mem_req` are all low.
- R11: Once raised, `mem_req` stays high with `mem_addr` unchanged until a cycle in which `mem_rvalid` is high. That cycle completes the read, and `mem_rdata` is taken in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle start pulse, honoured only when idle |
| base_addr | input | AW | Byte address of the list header |
| done_clr | input | 1 | Write-1 clear of the done flag |
| per_a | input | PW | Shape A frame period in cycles |
| hi_a | input | PW | Shape A high time in cycles |
| per_b | input | PW | Shape B frame period in cycles |
| hi_b | input | PW | Shape B high time in cycles |
| mem_req | output | 1 | Read request, held until accepted |
| mem_addr | output | AW | Byte address of the requested halfword |
| mem_rvalid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 16 | Read data halfword |
| ir_out | output | 1 | Modulated infrared output |
| busy | output | 1 | Sequencer is running |
| done | output | 1 | Sticky completion flag |

## Verification
The bench captures `ir_out` for every busy cycle and compares the tail of that capture against a waveform built from the descriptors. A design that miscounts frames, maps a zero count to anything but one frame, swaps the two shapes, or inserts a stall between segments shifts or corrupts that tail. The clamp test places a long extra descriptor right after the 256th entry, so a design that reads past the clamp plays hundreds of extra cycles. Zero and odd lengths must finish within a few cycles with no high output. A restart injected mid-run points at a different list, so a design that accepts it plays the wrong pattern. A slow-memory run checks that prefetching still hides the read latency.

// File: rtl/ir_seq_pkg.sv
package ir_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEN_LO,
        ST_LEN_HI,
        ST_LOAD,
        ST_PLAY
    } seq_state_t;

    typedef struct packed {
        logic        carrier;
        logic        shape_b;
        logic [13:0] frames;
    } ir_entry_t;

endpackage

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] period,
    input  logic [PW-1:0] high,
    output logic          pulse,
    output logic          frame_end
);
    logic [PW-1:0] cnt;
    logic [PW-1:0] last;

    // A zero period behaves as a one-cycle frame
    assign last      = (period == '0) ? '0 : period - 1'b1;
    assign frame_end = run && (cnt == last);
    assign pulse     = run && (cnt < high);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || frame_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ir_prefetch_buf.sv
module ir_prefetch_buf
    import ir_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clear,
    input  logic      fill,
    input  ir_entry_t fill_data,
    input  logic      take,
    output logic      valid,
    output ir_entry_t data
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            valid <= 1'b0;
            data  <= '0;
        end else if (fill) begin
            valid <= 1'b1;
            data  <= fill_data;
        end else if (take) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/ir_wave_seq.sv
module ir_wave_seq
    import ir_seq_pkg::*;
#(
    parameter int AW      = 32,
    parameter int PW      = 16,
    parameter int MAX_ENT = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic          done_clr,
    input  logic [PW-1:0] per_a,
    input  logic [PW-1:0] hi_a,
    input  logic [PW-1:0] per_b,
    input  logic [PW-1:0] hi_b,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [15:0]   mem_rdata,
    output logic          ir_out,
    output logic          busy,
    output logic          done
);
    localparam int CW        = $clog2(MAX_ENT + 1);
    localparam int MAX_BYTES = 2 * MAX_ENT;

    seq_state_t    st, st_nx;
    logic [AW-1:0] base_q;
    logic [AW-1:0] fetch_addr;
    logic [15:0]   len_lo;
    logic [CW-1:0] fetch_left;
    ir_entry_t     cur;
    logic [13:0]   frames_left;
    logic          done_q;

    logic          pf_valid;
    ir_entry_t     pf_data;
    logic [31:0]   len_full;
    logic          len_bad;
    logic [CW-1:0] n_entries;
    logic          want_entry;
    logic          xfer;
    logic          fill;
    logic          take;
    logic          finish;
    logic          seg_end;
    logic          run;
    logic [PW-1:0] sel_per;
    logic [PW-1:0] sel_hi;
    logic          pulse;
    logic          frame_end;

    assign len_full  = {mem_rdata, len_lo};
    assign len_bad   = (len_full == 32'd0) || len_full[0];
    assign n_entries = (len_full > 32'(MAX_BYTES)) ? CW'(MAX_ENT) : CW'(len_full >> 1);
    assign run       = (st == ST_PLAY);
    assign sel_per   = cur.shape_b ? per_b : per_a;
    assign sel_hi    = cur.shape_b ? hi_b  : hi_a;
    assign seg_end   = frame_end && (frames_left == 14'd1);

    ir_carrier_gen #(.PW(PW)) u_carrier (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .period    (sel_per),
        .high      (sel_hi),
        .pulse     (pulse),
        .frame_end (frame_end)
    );

    ir_prefetch_buf u_pf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (st == ST_IDLE),
        .fill      (fill),
        .fill_data (ir_entry_t'(mem_rdata)),
        .take      (take),
        .valid     (pf_valid),
        .data      (pf_data)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // Next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (start) st_nx = ST_LEN_LO;
            ST_LEN_LO: if (xfer)  st_nx = ST_LEN_HI;
            ST_LEN_HI: if (xfer)  st_nx = len_bad ? ST_IDLE : ST_LOAD;
            ST_LOAD:   if (pf_valid) st_nx = ST_PLAY;
            ST_PLAY: begin
                if (seg_end) begin
                    if (pf_valid)             st_nx = ST_PLAY;
                    else if (fetch_left != 0) st_nx = ST_LOAD;
                    else                      st_nx = ST_IDLE;
                end
            end
            default:   st_nx = ST_IDLE;
        endcase
    end

    // Outputs and control strobes
    always_comb begin
        want_entry = ((st == ST_LOAD) || (st == ST_PLAY)) && (fetch_left != 0) && !pf_valid;
        mem_req    = (st == ST_LEN_LO) || (st == ST_LEN_HI) || want_entry;
        unique case (st)
            ST_LEN_LO: mem_addr = base_q;
            ST_LEN_HI: mem_addr = base_q + AW'(2);
            default:   mem_addr = fetch_addr;
        endcase
        xfer   = mem_req && mem_rvalid;
        fill   = want_entry && mem_rvalid;
        take   = pf_valid && ((st == ST_LOAD) || ((st == ST_PLAY) && seg_end));
        finish = ((st == ST_LEN_HI) && xfer && len_bad) ||
                 ((st == ST_PLAY) && seg_end && !pf_valid && (fetch_left == 0));
        ir_out = run && cur.carrier && pulse;
        busy   = (st != ST_IDLE);
        done   = done_q;
    end

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q      <= '0;
            fetch_addr  <= '0;
            len_lo      <= '0;
            fetch_left  <= '0;
            cur         <= '0;
            frames_left <= '0;
            done_q      <= 1'b0;
        end else begin
            if ((st == ST_IDLE) && start) begin
                base_q     <= base_addr;
                fetch_addr <= base_addr + AW'(4);
            end
            if ((st == ST_LEN_LO) && xfer) begin
                len_lo <= mem_rdata;
            end
            if ((st == ST_LEN_HI) && xfer) begin
                fetch_left <= len_bad ? '0 : n_entries;
            end else if (fill) begin
                fetch_left <= fetch_left - 1'b1;
                fetch_addr <= fetch_addr + AW'(2);
            end
            if (take) begin
                cur         <= pf_data;
                frames_left <= (pf_data.frames == '0) ? 14'd1 : pf_data.frames;
            end else if (run && frame_end) begin
                frames_left <= frames_left - 1'b1;
            end
            if (finish) begin
                done_q <= 1'b1;
            end else if (done_clr) begin
                done_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ir_wave_seq_chk.sv
module ir_wave_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          done_clr,
    input logic          ir_out,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rvalid
);
    a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ir_out);

    a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done && !done_clr |=> done);

    a_r8_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_clr && !busy |=> !done);

    a_r5_done_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));
endmodule

bind ir_wave_seq ir_wave_seq_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .done_clr   (done_clr),
    .ir_out     (ir_out),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid)
);

// File: tb/ir_wave_seq_bench.sv
module ir_wave_seq_bench;
    localparam int AW = 32;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          done_clr = 1'b0;
    logic [PW-1:0] per_a = 16'd8, hi_a = 16'd3, per_b = 16'd6, hi_b = 16'd2;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid;
    logic [15:0]   mem_rdata;
    logic          ir_out, busy, done;

    logic [15:0] mem [0:1023];
    int lat = 0;
    int lat_cnt;
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;
    bit exp_q[$];
    bit cap_q[$];

    always #5 clk = ~clk;

    ir_wave_seq #(.AW(AW), .PW(PW)) u_ir_wave_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .done_clr(done_clr), .per_a(per_a), .hi_a(hi_a), .per_b(per_b), .hi_b(hi_b),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .ir_out(ir_out), .busy(busy), .done(done)
    );

    // Memory model: answers a held request after lat idle cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            lat_cnt    <= 0;
        end else if (mem_rvalid) begin
            mem_rvalid <= 1'b0;
        end else if (mem_req) begin
            if (lat_cnt >= lat) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_addr[10:1]];
                lat_cnt    <= 0;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic put_hdr(int base, int len);
        mem[(base >> 1)]     = len[15:0];
        mem[(base >> 1) + 1] = len[31:16];
    endtask

    task automatic put_ent(int base, int idx, logic [15:0] val);
        mem[(base >> 1) + 2 + idx] = val;
    endtask

    // Expected frames of one descriptor (R2, R3)
    task automatic add_seg(logic [15:0] e);
        int p, h, fr;
        p  = e[14] ? int'(per_b) : int'(per_a);
        h  = e[14] ? int'(hi_b)  : int'(hi_a);
        fr = (e[13:0] == 0) ? 1 : int'(e[13:0]);
        for (int f = 0; f < fr; f++)
            for (int k = 0; k < p; k++)
                exp_q.push_back(e[15] && (k < h));
    endtask

    task automatic clear_done();
        @(negedge clk) done_clr = 1'b1;
        @(negedge clk) done_clr = 1'b0;
    endtask

    // Starts a run, captures ir_out over busy cycles; optional restart at cycle inject
    task automatic run_capture(int base, int inject, int alt);
        int n;
        cap_q.delete();
        @(negedge clk);
        start = 1'b1;
        base_addr = AW'(base);
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (busy && n < 20000) begin
            cap_q.push_back(ir_out);
            if (n == inject) begin
                start = 1'b1;
                base_addr = AW'(alt);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
    endtask

    task automatic compare(string req, int max_lead);
        int lead, bad;
        lead = cap_q.size() - exp_q.size();
        check(lead >= 1 && lead <= max_lead, req, "lead-in cycles", lead, max_lead);
        bad = 0;
        if (lead >= 0) begin
            for (int i = 0; i < lead; i++) if (cap_q[i]) bad++;
            for (int i = 0; i < exp_q.size(); i++) if (cap_q[lead + i] != exp_q[i]) bad++;
        end
        check(bad == 0, req, "waveform mismatches", bad, 0);
        check(done && !busy, req, "done after run", int'(done), 1);
    endtask

    task automatic t_reset();
        check(!busy && !done && !ir_out && !mem_req, "R10", "reset idle",
              int'({busy, done, ir_out, mem_req}), 0);
    endtask

    task automatic t_basic();
        // R1 R2 R3 R4 R5: carrier A x3, silent A x2, carrier B x2
        put_hdr(0, 6);
        put_ent(0, 0, 16'h8003);
        put_ent(0, 1, 16'h0002);
        put_ent(0, 2, 16'hC002);
        exp_q.delete();
        add_seg(16'h8003); add_seg(16'h0002); add_seg(16'hC002);
        clear_done();
        run_capture(0, -1, 0);
        compare("R1 R2 R3 R4 R5", 10);
    endtask

    task automatic t_zero_count();
        // R2: count 0 plays one frame
        put_hdr('h40, 4);
        put_ent('h40, 0, 16'hC000);
        put_ent('h40, 1, 16'h8001);
        exp_q.delete();
        add_seg(16'hC000); add_seg(16'h8001);
        clear_done();
        run_capture('h40, -1, 0);
        compare("R2", 10);
    endtask

    task automatic t_bad_len(int base, int len);
        int highs;
        put_hdr(base, len);
        put_ent(base, 0, 16'h8005);
        clear_done();
        check(!done, "R8", "done cleared", int'(done), 0);
        run_capture(base, -1, 0);
        highs = 0;
        foreach (cap_q[i]) if (cap_q[i]) highs++;
        check(highs == 0, "R6", "high samples", highs, 0);
        check(cap_q.size() <= 6, "R6", "busy cycles", cap_q.size(), 6);
        check(done && !busy, "R6", "done on bad length", int'(done), 1);
    endtask

    task automatic t_clamp();
        // R7: 1000 bytes clamps to 256 entries, entry 256 must never play
        per_a = 16'd4; hi_a = 16'd2;
        put_hdr('h200, 1000);
        exp_q.delete();
        for (int i = 0; i < 256; i++) begin
            put_ent('h200, i, 16'h8001);
            add_seg(16'h8001);
        end
        put_ent('h200, 256, 16'h8064);
        clear_done();
        run_capture('h200, -1, 0);
        compare("R7", 10);
        per_a = 16'd8; hi_a = 16'd3;
    endtask

    task automatic t_busy_start();
        // R9: restart into another list mid-run is ignored
        put_hdr('h600, 2);
        put_ent('h600, 0, 16'h8100);
        exp_q.delete();
        add_seg(16'h8003); add_seg(16'h0002); add_seg(16'hC002);
        clear_done();
        run_capture(0, 20, 'h600);
        compare("R9", 10);
    endtask

    task automatic t_done_hold();
        // R8: done sticks until cleared
        repeat (20) @(negedge clk);
        check(done, "R8", "done held", int'(done), 1);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        check(!done, "R8", "done cleared by pulse", int'(done), 0);
        check(!ir_out && !busy, "R10", "idle output low", int'(ir_out), 0);
    endtask

    task automatic t_slow_mem();
        // R4 R11: slow reads still give gap-free segments
        lat = 3;
        per_a = 16'd10; hi_a = 16'd4;
        put_hdr('h700, 8);
        put_ent('h700, 0, 16'h8002);
        put_ent('h700, 1, 16'h0002);
        put_ent('h700, 2, 16'h8003);
        put_ent('h700, 3, 16'h4002);
        exp_q.delete();
        add_seg(16'h8002); add_seg(16'h0002); add_seg(16'h8003); add_seg(16'h4002);
        clear_done();
        run_capture('h700, -1, 0);
        compare("R4 R11", 30);
        lat = 0;
        per_a = 16'd8; hi_a = 16'd3;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_zero_count();
        t_bad_len('h80, 0);
        t_bad_len('hA0, 5);
        t_clamp();
        t_busy_start();
        t_done_hold();
        t_slow_mem();
        summary();
    end
endmodule